// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits between one bus master and the slave fabric. It splits the master's 32-bit address space into sixteen equal 256 MB windows. Each window is sent to a chosen slave number and to a chosen 256 MB window inside that slave. The top four address bits pick the window. The window's target index replaces those four bits, and the low 28 bits pass through unchanged. A window whose slave number is zero has no slave behind it, so any access that lands there is reported as a decode error.

Software sets up the map through a small word-addressed register port. Writes go into staging registers, and those are what a read returns. Nothing changes in the live map until software writes a 1 to the commit register; the whole staged map is then copied into the live map in one clock edge. Translation is pipelined with one register stage: a request presented with a valid strobe produces its slave number, remapped address and error flag, together with an output strobe, one cycle later.

Top module: `aperture_remap`

## Requirements
- R1: Address bits 31:28 select one of 16 windows, and `out_slave` is that window's live slave-select field.
- R2: `out_addr[31:28]` is the window's live target field, and `out_addr[27:0]` equals `in_addr[27:0]`.
- R3: Slave-select fields are staged at byte offset 0x0 (windows 0 to 7) and 0x4 (windows 8 to 15); window w uses bits 4*(w mod 8)+3 down to 4*(w mod 8).
- R4: Target fields are staged the same way at offset 0x8 (windows 0 to 7) and 0xC (windows 8 to 15).
- R5: Staged values reach the live map only on a write to offset 0x10 with data bit 0 set, and then all of them at once; a write there with bit 0 clear has no effect.
- R6: `out_err` is 1 exactly when the returned slave number is 0.
- R7: After reset `out_valid` is 0, every window selects slave 0 and targets its own index, so offsets 0x0 and 0x4 read 0, 0x8 reads 0x76543210 and 0xC reads 0xFEDCBA98.
- R8: A read pulse on `cfg_rd` returns the staged (not the live) value of the addressed register on `cfg_rdata` in the next cycle.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high.
- R10: A request in the same cycle as a commit write is translated with the old map; the next request uses the new one.
- R11: Writes to any offset other than 0x0, 0x4, 0x8, 0xC and 0x10 change nothing, and reads from any offset other than 0x0 to 0xC return 0 (0x10 reads as 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | RA_W (5) | Register byte offset |
| cfg_wdata | input | DATA_W (32) | Register write data |
| cfg_rdata | output | DATA_W (32) | Read data, one cycle after `cfg_rd` |
| in_valid | input | 1 | Translation request strobe |
| in_addr | input | ADDR_W (32) | Master address |
| out_valid | output | 1 | Result strobe |
| out_slave | output | APER_W (4) | Target slave number |
| out_addr | output | ADDR_W (32) | Remapped address |
| out_err | output | 1 | Decode error (window has no slave) |

## Verification
The bench builds the block with its default parameters: a 32-bit address, four window-index bits and a 5-bit register offset. These values give the sixteen-window, two-words-per-field layout, so every nibble position in both staging word pairs and every window can be reached. The 5-bit offset also covers the unused offsets 0x14 to 0x1C, so writes to undefined registers and reads from them can be driven. A programmed map with slaves in both halves and gaps of slave 0 is used for the table walk. Directed cases cover the reset map, staged-but-uncommitted writes, a commit with bit 0 clear, and a commit in the same cycle as a request.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Kind of register addressed on the configuration port.
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_SEL  = 2'd1,
    RK_OFF  = 2'd2,
    RK_CMT  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg #(
  parameter int APER_W  = 4,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32,
  parameter int RA_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic                              cfg_rd,
  input  logic [RA_W-1:0]                   cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [DATA_W-1:0]                 cfg_rdata,
  output logic [(1<<APER_W)-1:0][FIELD_W-1:0] live_sel,
  output logic [(1<<APER_W)-1:0][FIELD_W-1:0] live_tgt
);
  import remap_pkg::*;

  localparam int NUM_APER  = 1 << APER_W;
  localparam int PER_WORD  = DATA_W / FIELD_W;
  localparam int NUM_WORDS = NUM_APER / PER_WORD;
  localparam int IDX_W     = RA_W - 2;

  logic [NUM_APER-1:0][FIELD_W-1:0] stg_sel;
  logic [NUM_APER-1:0][FIELD_W-1:0] stg_tgt;

  logic [IDX_W-1:0] idx;
  reg_kind_e        kind;
  int               widx;
  logic             cmt_hit;
  logic [DATA_W-1:0] rd_sel_word;
  logic [DATA_W-1:0] rd_tgt_word;

  assign idx = cfg_addr[RA_W-1:2];

  // Offset decode: select words first, then target words, then commit.
  always_comb begin
    kind = RK_NONE;
    widx = 0;
    if (cfg_addr[1:0] == 2'b00) begin
      if (int'(idx) < NUM_WORDS) begin
        kind = RK_SEL;
        widx = int'(idx);
      end else if (int'(idx) < 2 * NUM_WORDS) begin
        kind = RK_OFF;
        widx = int'(idx) - NUM_WORDS;
      end else if (int'(idx) == 2 * NUM_WORDS) begin
        kind = RK_CMT;
      end
    end
  end

  assign cmt_hit = cfg_we && (kind == RK_CMT) && cfg_wdata[0];

  // Gather the staged nibbles of the addressed word.
  for (genvar n = 0; n < PER_WORD; n++) begin : g_rd
    assign rd_sel_word[n*FIELD_W +: FIELD_W] = stg_sel[widx*PER_WORD + n];
    assign rd_tgt_word[n*FIELD_W +: FIELD_W] = stg_tgt[widx*PER_WORD + n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < NUM_APER; a++) begin
        stg_sel[a]  <= '0;
        stg_tgt[a]  <= FIELD_W'(a);
        live_sel[a] <= '0;
        live_tgt[a] <= FIELD_W'(a);
      end
      cfg_rdata <= '0;
    end else begin
      for (int a = 0; a < NUM_APER; a++) begin
        if (cfg_we && kind == RK_SEL && widx == a / PER_WORD)
          stg_sel[a] <= cfg_wdata[(a % PER_WORD)*FIELD_W +: FIELD_W];
        if (cfg_we && kind == RK_OFF && widx == a / PER_WORD)
          stg_tgt[a] <= cfg_wdata[(a % PER_WORD)*FIELD_W +: FIELD_W];
      end
      if (cmt_hit) begin
        live_sel <= stg_sel;
        live_tgt <= stg_tgt;
      end
      if (cfg_rd) begin
        case (kind)
          RK_SEL:  cfg_rdata <= rd_sel_word;
          RK_OFF:  cfg_rdata <= rd_tgt_word;
          default: cfg_rdata <= '0;
        endcase
      end else begin
        cfg_rdata <= '0;
      end
    end
  end

  // R5: live map holds unless a commit was written
  a_r5_live_hold: assert property (@(posedge clk) disable iff (rst)
    !cmt_hit |=> ($stable(live_sel) && $stable(live_tgt)));

  // R5: commit loads the whole staged map
  a_r5_commit_load: assert property (@(posedge clk) disable iff (rst)
    cmt_hit |=> (live_sel == $past(stg_sel) && live_tgt == $past(stg_tgt)));

  // R11: reads outside the staging words return zero
  a_r11_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && kind != RK_SEL && kind != RK_OFF) |=> (cfg_rdata == '0));
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int ADDR_W = 32,
  parameter int APER_W = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [(1<<APER_W)-1:0][APER_W-1:0] live_sel,
  input  logic [(1<<APER_W)-1:0][APER_W-1:0] live_tgt,
  input  logic                              in_valid,
  input  logic [ADDR_W-1:0]                 in_addr,
  output logic                              out_valid,
  output logic [APER_W-1:0]                 out_slave,
  output logic [ADDR_W-1:0]                 out_addr,
  output logic                              out_err
);
  localparam int LOW_W = ADDR_W - APER_W;

  logic [APER_W-1:0] win;
  assign win = in_addr[ADDR_W-1:LOW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_slave <= '0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_slave <= live_sel[win];
        out_addr  <= {live_tgt[win], in_addr[LOW_W-1:0]};
        out_err   <= (live_sel[win] == '0);
      end
    end
  end

  // R9: one result strobe per request, one cycle later
  a_r9_strobe_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2: low address bits pass through
  a_r2_low_pass: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_addr[LOW_W-1:0] == $past(in_addr[LOW_W-1:0])));

  // R6: error flag agrees with the returned slave number
  a_r6_err_match: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_err == (out_slave == '0)));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int ADDR_W = 32,
  parameter int APER_W = 4,
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_rd,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [APER_W-1:0] out_slave,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  localparam int NUM_APER = 1 << APER_W;
  localparam int FIELD_W  = APER_W;

  logic [NUM_APER-1:0][FIELD_W-1:0] live_sel;
  logic [NUM_APER-1:0][FIELD_W-1:0] live_tgt;

  remap_cfg #(
    .APER_W (APER_W),
    .FIELD_W(FIELD_W),
    .DATA_W (DATA_W),
    .RA_W   (RA_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .live_sel (live_sel),
    .live_tgt (live_tgt)
  );

  remap_xlate #(
    .ADDR_W(ADDR_W),
    .APER_W(APER_W)
  ) u_xlate (
    .clk      (clk),
    .rst      (rst),
    .live_sel (live_sel),
    .live_tgt (live_tgt),
    .in_valid (in_valid),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_slave(out_slave),
    .out_addr (out_addr),
    .out_err  (out_err)
  );
endmodule

// File: tb/test_aperture_remap.sv
module test_aperture_remap;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  slv;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  // Map programmed below: SEL 0x30000120 / 0x60050087, TGT 0xA00000C3 / 0x12345678
  localparam vec_t VECS [9] = '{
    '{32'h1ABC_DEF0, 4'h2, 32'hCABC_DEF0, 1'b0},
    '{32'h2000_0004, 4'h1, 32'h0000_0004, 1'b0},
    '{32'h0FFF_FFFF, 4'h0, 32'h3FFF_FFFF, 1'b1},
    '{32'h7123_4567, 4'h3, 32'hA123_4567, 1'b0},
    '{32'h8000_0000, 4'h7, 32'h8000_0000, 1'b0},
    '{32'h9FFF_FFFF, 4'h8, 32'h7FFF_FFFF, 1'b0},
    '{32'hC000_1000, 4'h5, 32'h4000_1000, 1'b0},
    '{32'hF00D_BEEF, 4'h6, 32'h100D_BEEF, 1'b0},
    '{32'hA555_5555, 4'h0, 32'h6555_5555, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic [3:0]  out_slave;
  logic [31:0] out_addr;
  logic        out_err;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aperture_remap i_aperture_remap (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_slave(out_slave),
    .out_addr(out_addr), .out_err(out_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic xl(input logic [31:0] a, input logic [3:0] s, input logic [31:0] e,
                    input logic er, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " slave"}, {28'd0, out_slave}, {28'd0, s});
    check({tag, " addr"},  out_addr, e);
    check({tag, " err"},   {31'd0, out_err}, {31'd0, er});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    check("R7 out_valid after reset", {31'd0, out_valid}, 32'd0);
    rd(5'h00, 32'h0000_0000, "R7 sel lo reset");
    rd(5'h04, 32'h0000_0000, "R7 sel hi reset");
    rd(5'h08, 32'h7654_3210, "R7 tgt lo reset");
    rd(5'h0C, 32'hFEDC_BA98, "R7 tgt hi reset");
    xl(32'h5123_4567, 4'h0, 32'h5123_4567, 1'b1, "R7 R6 identity map");

    // R3 R4: staging writes and packing readback
    wr(5'h00, 32'h3000_0120);
    wr(5'h04, 32'h6005_0087);
    wr(5'h08, 32'hA000_00C3);
    wr(5'h0C, 32'h1234_5678);
    rd(5'h00, 32'h3000_0120, "R3 sel lo staged");
    rd(5'h04, 32'h6005_0087, "R3 sel hi staged");
    rd(5'h08, 32'hA000_00C3, "R4 tgt lo staged");
    rd(5'h0C, 32'h1234_5678, "R4 tgt hi staged");

    // R5 R8: staged map not yet live
    xl(32'h1ABC_DEF0, 4'h0, 32'h1ABC_DEF0, 1'b1, "R5 R8 before commit");
    wr(5'h10, 32'hFFFF_FFFE);
    xl(32'h1ABC_DEF0, 4'h0, 32'h1ABC_DEF0, 1'b1, "R5 commit bit0 clear");

    // R11: undefined offsets
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h14, 32'h0, "R11 read 0x14");
    rd(5'h10, 32'h0, "R11 read commit reg");
    rd(5'h00, 32'h3000_0120, "R11 sel lo untouched");
    rd(5'h0C, 32'h1234_5678, "R11 tgt hi untouched");
    xl(32'h1ABC_DEF0, 4'h0, 32'h1ABC_DEF0, 1'b1, "R11 live map untouched");

    // R10: commit in the same cycle as a request
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'h10; cfg_wdata = 32'h1;
    in_valid = 1'b1; in_addr = 32'h1ABC_DEF0;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R10 same-cycle slave", {28'd0, out_slave}, 32'd0);
    check("R10 same-cycle addr", out_addr, 32'h1ABC_DEF0);
    check("R10 same-cycle err", {31'd0, out_err}, 32'd1);
    // R9: no request -> no strobe
    @(negedge clk);
    check("R9 idle strobe", {31'd0, out_valid}, 32'd0);
    xl(32'h1ABC_DEF0, 4'h2, 32'hCABC_DEF0, 1'b0, "R10 next request new map");

    // R1 R2 R6 R9: table walk
    for (int i = 0; i < 9; i++) begin
      xl(VECS[i].addr, VECS[i].slv, VECS[i].exp, VECS[i].err, $sformatf("R1 R2 R6 vec%0d", i));
    end

    // R8: restage without commit, readback staged, live map unchanged
    wr(5'h00, 32'h0000_0000);
    rd(5'h00, 32'h0000_0000, "R8 staged readback");
    xl(32'h1000_0000, 4'h2, 32'hC000_0000, 1'b0, "R8 R5 live keeps old");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule